// File: doc/BRIEF.md
# Block-Counted Pseudo-DMA Buffer Engine

This engine moves bytes between a host byte port and a SCSI data bus through one staging buffer. The unit of transfer is a block. A block's length is the smaller of the buffer depth and the target's transfer length. Software loads a block count and chooses a direction. The host side and the bus side then take turns owning the buffer. A not-ready flag says which side owns it at a given moment.

When sending, software writes a block into the buffer through a single port. A filled buffer raises not-ready and busy, and the bus side then drains it with a REQ/ACK handshake. When receiving, the bus side fills the buffer, and software then drains it through the same port. Each block completed on the bus decrements an 8-bit count, which wraps modulo 256, so loading zero means 256 blocks.

The end of the transfer sets an end-of-DMA flag and can raise an interrupt. On a send this happens when the count runs out. On a receive it happens when the host drains the final block. The engine also leaves DMA mode if BSY drops while bus monitoring is enabled.

Top module: `pdma_engine`

## Requirements
- R1: The effective block length is min(BUF_DEPTH, tgt_len). The bus moves exactly that many bytes per block, and a length of zero moves nothing.
- R2: Sending (dir_recv_in = 0) works as follows:
  - Each host_wr stores host_wdata at the host pointer and advances it.
  - The write that reaches the block length sets not_ready and busy in the same cycle.
  - Writes made with the pointer at the block length are ignored.
- R3: Receiving (dir_recv_in = 1) works as follows:
  - host_rdata shows the byte at the host pointer, and host_rd advances the pointer.
  - host_rdata reads 0xFF when the pointer is at the block length or the direction is send.
  - host_wr has no effect while receiving.
- R4: The bus side works as follows:
  - It waits for scsi_req.
  - It raises scsi_ack for exactly one cycle per byte, then holds it low for at least one cycle.
  - On a send, scsi_dout carries the next buffer byte while ack is high and scsi_dout_en is 1.
  - On a receive, it captures scsi_din on the cycle it sees req.
  - Bytes go in buffer order.
- R5: When a block completes on the bus side:
  - not_ready and busy clear, and both pointers return to 0.
  - blk_count decrements modulo 256, so a loaded count of 0 runs 256 blocks.
- R6: When a send block completes with blk_count at 1:
  - dma_mode and cnt_loaded clear.
  - last_byte_sent and end_of_dma set.
  - irq sets only if eop_irq_en is 1.
- R7: On a receive, end_of_dma and irq (gated by eop_irq_en) set, and dma_mode clears, only when the host reads the last byte of a block while cnt_loaded is 0. Draining a block while a count is still loaded sets neither flag.
- R8: A cnt_wr pulse does the following:
  - It loads blk_count and sets cnt_loaded.
  - On a receive, it sets not_ready and moves the host pointer to the block length.
  - On a send, it clears not_ready and zeroes the host pointer.
  - It restarts the bus side.
  - The bus side never raises ack unless cnt_loaded, dma_mode and not_ready are all 1.
- R9: If mon_bsy is 1 and scsi_bsy is 0 while in DMA mode, dma_mode and cnt_loaded clear on the next edge and the bus side stops. With mon_bsy at 0, scsi_bsy is ignored.
- R10: A dma_start pulse sets dma_mode and clears end_of_dma, last_byte_sent and irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host port write strobe |
| host_rd | input | 1 | Host port read strobe |
| host_wdata | input | DATA_W | Host write byte |
| host_rdata | output | DATA_W | Byte at the host pointer, or all ones |
| dir_recv_in | input | 1 | 1 = receive (bus to host), 0 = send |
| tgt_len | input | LEN_W | Target transfer length in bytes |
| cnt_wr | input | 1 | Load the block count |
| cnt_wdata | input | CNT_W | Block count value |
| dma_start | input | 1 | Enter DMA mode, clear completion flags |
| eop_irq_en | input | 1 | Allow irq at end of DMA |
| mon_bsy | input | 1 | Enable BSY monitoring |
| scsi_req | input | 1 | Target REQ |
| scsi_ack | output | 1 | Initiator ACK pulse |
| scsi_bsy | input | 1 | Bus BSY |
| scsi_din | input | DATA_W | Data from the bus |
| scsi_dout | output | DATA_W | Data to the bus |
| scsi_dout_en | output | 1 | Drive scsi_dout onto the bus |
| not_ready | output | 1 | Buffer owned by the bus side |
| busy | output | 1 | Send block waiting to be drained |
| cnt_loaded | output | 1 | A block count is active |
| blk_count | output | CNT_W | Remaining block count |
| dma_mode | output | 1 | DMA mode active |
| end_of_dma | output | 1 | Transfer completed |
| last_byte_sent | output | 1 | Send transfer completed |
| irq | output | 1 | End-of-DMA interrupt |

## Verification
The bench builds the engine with BUF_DEPTH = 8, keeping every other parameter at its default. Short blocks let it cover several regimes within a few thousand cycles:
- Clamping of a longer target length to the buffer depth, and a length below the depth.
- A full 256-block run from a loaded count of zero, which exercises the modulo-256 wrap.
- Multi-block sends and receives, where ownership of the buffer passes back and forth.

A REQ line that stays low pins the bus side in its wait state, which lets the bench exercise the BSY-drop abort with a block pending.

// File: rtl/pdma_pkg.sv
`timescale 1ns/1ps
package pdma_pkg;

    typedef enum logic [1:0] {
        BS_IDLE     = 2'd0,
        BS_WAIT_REQ = 2'd1,
        BS_ACK_HI   = 2'd2,
        BS_ACK_LO   = 2'd3
    } bus_state_e;

    typedef enum logic {
        DIR_SEND = 1'b0,
        DIR_RECV = 1'b1
    } xfer_dir_e;

    // Single-cycle events that move the shared flags.
    typedef struct packed {
        logic cnt_load;
        logic dir_rise;
        logic dir_fall;
        logic fill_last;
        logic drain_last;
        logic blk_done;
        logic bsy_abort;
    } pdma_evt_t;

    typedef struct packed {
        logic not_ready;
        logic busy;
        logic loaded;
        logic dma_mode;
        logic end_of_dma;
        logic last_sent;
        logic irq;
    } pdma_flags_t;

    function automatic logic is_recv(input logic d);
        return xfer_dir_e'(d) == DIR_RECV;
    endfunction

endpackage

// File: rtl/pdma_buffer.sv
`timescale 1ns/1ps
module pdma_buffer #(
    parameter int DEPTH  = 128,
    parameter int DATA_W = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic [AW-1:0]     raddr_b,
    output logic [DATA_W-1:0] rdata_b
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/pdma_host_port.sv
`timescale 1ns/1ps
module pdma_host_port
    import pdma_pkg::*;
#(
    parameter int DEPTH  = 128,
    parameter int DATA_W = 8,
    localparam int PW    = $clog2(DEPTH + 1),
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic              rd_stb,
    input  logic              dir_q,
    input  logic [PW-1:0]     eff_len,
    input  logic              set_full,
    input  logic              set_zero,
    input  logic [DATA_W-1:0] buf_rdata,
    output logic [AW-1:0]     buf_addr,
    output logic              wr_ok,
    output logic              fill_last,
    output logic              drain_last,
    output logic [DATA_W-1:0] rdata
);
    logic [PW-1:0] ptr;
    logic          in_block;
    logic          rd_ok;
    logic          hold;

    assign in_block   = ptr < eff_len;
    assign hold       = set_full | set_zero;
    assign wr_ok      = wr_stb & ~is_recv(dir_q) & in_block & ~hold;
    assign rd_ok      = rd_stb &  is_recv(dir_q) & in_block & ~hold;
    assign fill_last  = wr_ok & ((ptr + PW'(1)) == eff_len);
    assign drain_last = rd_ok & ((ptr + PW'(1)) == eff_len);
    assign buf_addr   = ptr[AW-1:0];
    assign rdata      = (is_recv(dir_q) && in_block) ? buf_rdata : '1;

    always_ff @(posedge clk) begin
        if (rst)                 ptr <= PW'(DEPTH);
        else if (set_full)       ptr <= eff_len;
        else if (set_zero)       ptr <= '0;
        else if (wr_ok || rd_ok) ptr <= ptr + PW'(1);
    end
endmodule

// File: rtl/pdma_bus_seq.sv
`timescale 1ns/1ps
module pdma_bus_seq
    import pdma_pkg::*;
#(
    parameter int DEPTH  = 128,
    parameter int DATA_W = 8,
    localparam int PW    = $clog2(DEPTH + 1),
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic              abort,
    input  logic              dir_q,
    input  logic [PW-1:0]     eff_len,
    input  logic              req,
    input  logic [DATA_W-1:0] buf_rdata,
    output logic [AW-1:0]     buf_addr,
    output logic              buf_we,
    output logic              ack,
    output logic              dout_en,
    output logic [DATA_W-1:0] dout,
    output logic              blk_done
);
    bus_state_e    state;
    logic [PW-1:0] bptr;
    logic          at_end;

    assign at_end   = (bptr + PW'(1)) == eff_len;
    assign buf_addr = bptr[AW-1:0];
    assign blk_done = (state == BS_ACK_LO) && at_end && !abort;
    assign buf_we   = is_recv(dir_q) && (state == BS_WAIT_REQ) && req && !abort;
    assign ack      = (state == BS_ACK_HI);
    assign dout_en  = !is_recv(dir_q) && (state != BS_IDLE);
    assign dout     = buf_rdata;

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            state <= BS_IDLE;
            bptr  <= '0;
        end else begin
            unique case (state)
                BS_IDLE:     if (go) state <= BS_WAIT_REQ;
                BS_WAIT_REQ: if (req) state <= BS_ACK_HI;
                BS_ACK_HI:   state <= BS_ACK_LO;
                BS_ACK_LO: begin
                    if (at_end) begin
                        bptr  <= '0;
                        state <= BS_IDLE;
                    end else begin
                        bptr  <= bptr + PW'(1);
                        state <= BS_WAIT_REQ;
                    end
                end
                default:     state <= BS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pdma_flags.sv
`timescale 1ns/1ps
module pdma_flags
    import pdma_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  pdma_evt_t        evt,
    input  logic             dir_in,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             dma_start,
    input  logic             eop_en,
    output logic             dir_q,
    output logic [CNT_W-1:0] count,
    output pdma_flags_t      fl
);
    logic final_send;
    logic final_recv;

    assign final_send = evt.blk_done && (count == CNT_W'(1)) && !is_recv(dir_q);
    assign final_recv = evt.drain_last && !fl.loaded;

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= 1'b0;
            count <= '0;
            fl    <= '0;
        end else begin
            dir_q <= dir_in;

            if (evt.cnt_load)        fl.not_ready <= dir_in;
            else if (evt.dir_rise)   fl.not_ready <= 1'b1;
            else if (evt.dir_fall)   fl.not_ready <= 1'b0;
            else if (evt.blk_done)   fl.not_ready <= 1'b0;
            else if (evt.fill_last || evt.drain_last) fl.not_ready <= 1'b1;

            if (evt.fill_last)       fl.busy <= 1'b1;
            else if (evt.blk_done)   fl.busy <= 1'b0;

            if (evt.cnt_load)        count <= cnt_val;
            else if (evt.blk_done)   count <= count - CNT_W'(1);

            if (evt.bsy_abort)       fl.loaded <= 1'b0;
            else if (evt.cnt_load)   fl.loaded <= 1'b1;
            else if (evt.blk_done && count == CNT_W'(1)) fl.loaded <= 1'b0;

            if (evt.bsy_abort || final_send || final_recv) fl.dma_mode <= 1'b0;
            else if (dma_start)      fl.dma_mode <= 1'b1;

            if (dma_start) begin
                fl.end_of_dma <= 1'b0;
                fl.last_sent  <= 1'b0;
                fl.irq        <= 1'b0;
            end else if (final_send) begin
                fl.end_of_dma <= 1'b1;
                fl.last_sent  <= 1'b1;
                fl.irq        <= fl.irq | eop_en;
            end else if (final_recv) begin
                fl.end_of_dma <= 1'b1;
                fl.irq        <= fl.irq | eop_en;
            end
        end
    end
endmodule

// File: rtl/pdma_engine.sv
`timescale 1ns/1ps
module pdma_engine
    import pdma_pkg::*;
#(
    parameter int BUF_DEPTH = 128,
    parameter int DATA_W    = 8,
    parameter int CNT_W     = 8,
    parameter int LEN_W     = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              dir_recv_in,
    input  logic [LEN_W-1:0]  tgt_len,
    input  logic              cnt_wr,
    input  logic [CNT_W-1:0]  cnt_wdata,
    input  logic              dma_start,
    input  logic              eop_irq_en,
    input  logic              mon_bsy,
    input  logic              scsi_req,
    output logic              scsi_ack,
    input  logic              scsi_bsy,
    input  logic [DATA_W-1:0] scsi_din,
    output logic [DATA_W-1:0] scsi_dout,
    output logic              scsi_dout_en,
    output logic              not_ready,
    output logic              busy,
    output logic              cnt_loaded,
    output logic [CNT_W-1:0]  blk_count,
    output logic              dma_mode,
    output logic              end_of_dma,
    output logic              last_byte_sent,
    output logic              irq
);
    localparam int PW = $clog2(BUF_DEPTH + 1);
    localparam int AW = $clog2(BUF_DEPTH);

    logic [PW-1:0]     eff_len;
    logic              dir_q;
    pdma_evt_t         evt;
    pdma_flags_t       fl;
    logic [AW-1:0]     host_addr, bus_addr, waddr;
    logic [DATA_W-1:0] host_buf_q, bus_buf_q, wdata;
    logic              host_wr_ok, bus_we, we;
    logic              fill_last, drain_last, blk_done;
    logic              seq_go, seq_abort;

    assign eff_len = (tgt_len > LEN_W'(BUF_DEPTH)) ? PW'(BUF_DEPTH) : tgt_len[PW-1:0];

    assign evt.cnt_load   = cnt_wr;
    assign evt.dir_rise   = dir_recv_in & ~dir_q;
    assign evt.dir_fall   = ~dir_recv_in & dir_q;
    assign evt.fill_last  = fill_last;
    assign evt.drain_last = drain_last;
    assign evt.blk_done   = blk_done;
    assign evt.bsy_abort  = mon_bsy & ~scsi_bsy & fl.dma_mode;

    assign seq_abort = evt.cnt_load | evt.dir_rise | evt.dir_fall | evt.bsy_abort;
    assign seq_go    = fl.dma_mode & fl.loaded & fl.not_ready & (eff_len != '0);

    // Buffer write port: the bus fills when receiving, the host when sending.
    assign we    = is_recv(dir_q) ? bus_we   : host_wr_ok;
    assign waddr = is_recv(dir_q) ? bus_addr : host_addr;
    assign wdata = is_recv(dir_q) ? scsi_din : host_wdata;

    pdma_buffer #(.DEPTH(BUF_DEPTH), .DATA_W(DATA_W)) u_buf (
        .clk     (clk),
        .we      (we),
        .waddr   (waddr),
        .wdata   (wdata),
        .raddr_a (host_addr),
        .rdata_a (host_buf_q),
        .raddr_b (bus_addr),
        .rdata_b (bus_buf_q)
    );

    pdma_host_port #(.DEPTH(BUF_DEPTH), .DATA_W(DATA_W)) u_host (
        .clk        (clk),
        .rst        (rst),
        .wr_stb     (host_wr),
        .rd_stb     (host_rd),
        .dir_q      (dir_q),
        .eff_len    (eff_len),
        .set_full   ((cnt_wr & dir_recv_in) | evt.dir_rise),
        .set_zero   ((cnt_wr & ~dir_recv_in) | evt.dir_fall | blk_done),
        .buf_rdata  (host_buf_q),
        .buf_addr   (host_addr),
        .wr_ok      (host_wr_ok),
        .fill_last  (fill_last),
        .drain_last (drain_last),
        .rdata      (host_rdata)
    );

    pdma_bus_seq #(.DEPTH(BUF_DEPTH), .DATA_W(DATA_W)) u_bus (
        .clk       (clk),
        .rst       (rst),
        .go        (seq_go),
        .abort     (seq_abort),
        .dir_q     (dir_q),
        .eff_len   (eff_len),
        .req       (scsi_req),
        .buf_rdata (bus_buf_q),
        .buf_addr  (bus_addr),
        .buf_we    (bus_we),
        .ack       (scsi_ack),
        .dout_en   (scsi_dout_en),
        .dout      (scsi_dout),
        .blk_done  (blk_done)
    );

    pdma_flags #(.CNT_W(CNT_W)) u_flags (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .dir_in    (dir_recv_in),
        .cnt_val   (cnt_wdata),
        .dma_start (dma_start),
        .eop_en    (eop_irq_en),
        .dir_q     (dir_q),
        .count     (blk_count),
        .fl        (fl)
    );

    assign not_ready      = fl.not_ready;
    assign busy           = fl.busy;
    assign cnt_loaded     = fl.loaded;
    assign dma_mode       = fl.dma_mode;
    assign end_of_dma     = fl.end_of_dma;
    assign last_byte_sent = fl.last_sent;
    assign irq            = fl.irq;
endmodule

// File: rtl/pdma_checker.sv
`timescale 1ns/1ps
module pdma_checker #(
    parameter int CNT_W  = 8,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              scsi_ack,
    input logic              cnt_loaded,
    input logic              dma_mode,
    input logic              busy,
    input logic [CNT_W-1:0]  blk_count,
    input logic              last_byte_sent,
    input logic              irq,
    input logic              eop_irq_en,
    input logic              mon_bsy,
    input logic              scsi_bsy,
    input logic [DATA_W-1:0] host_rdata,
    input logic              dir_q
);
    a_r4_ack_single_cycle: assert property (@(posedge clk) disable iff (rst)
        scsi_ack |=> !scsi_ack);

    a_r5_count_steps_down: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> blk_count == $past(blk_count) - CNT_W'(1));

    a_r6_sent_leaves_dma: assert property (@(posedge clk) disable iff (rst)
        last_byte_sent |-> !dma_mode);

    a_r6_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(eop_irq_en));

    a_r8_ack_needs_load: assert property (@(posedge clk) disable iff (rst)
        scsi_ack |-> (cnt_loaded && dma_mode));

    a_r9_bsy_drop_abort: assert property (@(posedge clk) disable iff (rst)
        (mon_bsy && !scsi_bsy && dma_mode) |=> (!dma_mode && !cnt_loaded));

    a_r3_send_reads_ones: assert property (@(posedge clk) disable iff (rst)
        !dir_q |-> host_rdata == '1);
endmodule

bind pdma_engine pdma_checker #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .scsi_ack       (scsi_ack),
    .cnt_loaded     (cnt_loaded),
    .dma_mode       (dma_mode),
    .busy           (busy),
    .blk_count      (blk_count),
    .last_byte_sent (last_byte_sent),
    .irq            (irq),
    .eop_irq_en     (eop_irq_en),
    .mon_bsy        (mon_bsy),
    .scsi_bsy       (scsi_bsy),
    .host_rdata     (host_rdata),
    .dir_q          (dir_q)
);

// File: tb/tb_pdma_engine.sv
`timescale 1ns/1ps
module tb_pdma_engine;
    localparam int DEPTH = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_wr = 0, host_rd = 0, dir_recv_in = 0, cnt_wr = 0, dma_start = 0;
    logic       eop_irq_en = 0, mon_bsy = 0, scsi_req = 1, scsi_bsy = 1;
    logic [7:0] host_wdata = 0, cnt_wdata = 0, scsi_din = 8'h11;
    logic [15:0] tgt_len = 16'd20;
    logic [7:0] host_rdata, scsi_dout, blk_count;
    logic       scsi_ack, scsi_dout_en, not_ready, busy, cnt_loaded, dma_mode;
    logic       end_of_dma, last_byte_sent, irq;

    int n_chk = 0, n_err = 0, n_bus = 0;
    bit rx_mode = 0;
    logic [7:0] exp_q[$];

    always #2.5 clk = ~clk;

    pdma_engine #(.BUF_DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .dir_recv_in(dir_recv_in),
        .tgt_len(tgt_len), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .dma_start(dma_start),
        .eop_irq_en(eop_irq_en), .mon_bsy(mon_bsy), .scsi_req(scsi_req), .scsi_ack(scsi_ack),
        .scsi_bsy(scsi_bsy), .scsi_din(scsi_din), .scsi_dout(scsi_dout),
        .scsi_dout_en(scsi_dout_en), .not_ready(not_ready), .busy(busy),
        .cnt_loaded(cnt_loaded), .blk_count(blk_count), .dma_mode(dma_mode),
        .end_of_dma(end_of_dma), .last_byte_sent(last_byte_sent), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // Monitor side of the scoreboard: one byte per ACK-high cycle.
    always @(negedge clk) begin
        if (!rst && scsi_ack) begin
            n_bus++;
            if (rx_mode) begin
                exp_q.push_back(scsi_din);
                scsi_din <= scsi_din + 8'h1D;
            end else begin
                chk("R4 dout_en", {31'd0, scsi_dout_en}, 1);
                if (exp_q.size() == 0) chk("R4 unexpected byte", {24'd0, scsi_dout}, 32'hFFFF);
                else chk("R4 send byte", {24'd0, scsi_dout}, {24'd0, exp_q.pop_front()});
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic pulse_start();
        dma_start = 1; tick(); dma_start = 0;
    endtask

    task automatic load_cnt(input logic [7:0] v);
        cnt_wr = 1; cnt_wdata = v; tick(); cnt_wr = 0;
    endtask

    task automatic hwrite(input logic [7:0] v, input bit push);
        host_wr = 1; host_wdata = v; tick(); host_wr = 0;
        if (push) exp_q.push_back(v);
    endtask

    task automatic hread(input string req);
        logic [7:0] e;
        e = (exp_q.size() == 0) ? 8'hFF : exp_q.pop_front();
        host_rd = 1;
        chk(req, {24'd0, host_rdata}, {24'd0, e});
        tick(); host_rd = 0;
    endtask

    task automatic hread_ff(input string req);
        host_rd = 1;
        chk(req, {24'd0, host_rdata}, 32'hFF);
        tick(); host_rd = 0;
    endtask

    task automatic wait_busy_low();
        for (int i = 0; i < 2000 && busy; i++) tick();
    endtask

    task automatic wait_nr_low();
        for (int i = 0; i < 2000 && not_ready; i++) tick();
    endtask

    initial begin
        repeat (4) tick();
        rst = 0; tick();
        // Reset state
        chk("R8 reset loaded", {31'd0, cnt_loaded}, 0);
        chk("R5 reset count", {24'd0, blk_count}, 0);
        chk("R2 reset busy/nr", {30'd0, busy, not_ready}, 0);
        chk("R10 reset dma/eod/irq", {29'd0, dma_mode, end_of_dma, irq}, 0);
        chk("R3 reset rdata", {24'd0, host_rdata}, 32'hFF);

        // Send, two blocks, length clamped 20 -> 8
        tgt_len = 16'd20; eop_irq_en = 1;
        pulse_start(); load_cnt(8'd2);
        chk("R8 send load clears nr", {31'd0, not_ready}, 0);
        for (int i = 0; i < DEPTH; i++) hwrite(8'h40 + 8'(i), 1);
        chk("R2 filled nr+busy", {30'd0, not_ready, busy}, 3);
        hwrite(8'hEE, 0);
        wait_busy_low();
        chk("R1 clamped block bytes", n_bus, DEPTH);
        chk("R5 count after block", {24'd0, blk_count}, 1);
        chk("R5 nr cleared", {31'd0, not_ready}, 0);
        chk("R6 not final yet", {30'd0, cnt_loaded, end_of_dma}, 2);
        for (int i = 0; i < DEPTH; i++) hwrite(8'hA0 + 8'(i), 1);
        wait_busy_low();
        chk("R6 count zero", {24'd0, blk_count}, 0);
        chk("R6 loaded/dma clear", {30'd0, cnt_loaded, dma_mode}, 0);
        chk("R6 lbs/eod/irq", {29'd0, last_byte_sent, end_of_dma, irq}, 7);
        chk("R2 extra write ignored", exp_q.size(), 0);

        pulse_start();
        chk("R10 start clears flags", {28'd0, dma_mode, last_byte_sent, end_of_dma, irq}, 8);

        // Short block, irq disabled
        eop_irq_en = 0; tgt_len = 16'd5; n_bus = 0;
        load_cnt(8'd1);
        for (int i = 0; i < 5; i++) hwrite(8'h60 + 8'(i), 1);
        wait_busy_low();
        chk("R1 short block bytes", n_bus, 5);
        chk("R6 eod without irq", {30'd0, end_of_dma, irq}, 2);
        hread_ff("R3 read in send dir");

        // Receive, two blocks of 6
        rx_mode = 1; dir_recv_in = 1; tick();
        tgt_len = 16'd6; eop_irq_en = 1;
        pulse_start(); load_cnt(8'd2);
        chk("R8 recv load sets nr", {31'd0, not_ready}, 1);
        hread_ff("R3 read while bus owns");
        wait_nr_low();
        chk("R5 recv count", {24'd0, blk_count}, 1);
        hwrite(8'hAA, 0);
        for (int i = 0; i < 6; i++) hread("R3 recv byte");
        hread_ff("R3 read past length");
        chk("R7 no eod while loaded", {31'd0, end_of_dma}, 0);
        wait_nr_low();
        chk("R7 final block loaded clear", {30'd0, cnt_loaded, end_of_dma}, 0);
        for (int i = 0; i < 6; i++) hread("R3 recv byte 2");
        chk("R7 eod/irq after drain", {30'd0, end_of_dma, irq}, 3);
        chk("R7 dma cleared", {31'd0, dma_mode}, 0);

        // Bus idle without a loaded count
        rx_mode = 0; dir_recv_in = 0; tick();
        tgt_len = 16'd5; pulse_start(); n_bus = 0;
        for (int i = 0; i < 5; i++) hwrite(8'h70 + 8'(i), 0);
        repeat (20) tick();
        chk("R8 no ack unloaded", n_bus, 0);
        load_cnt(8'd1);
        chk("R8 send load resets nr", {31'd0, not_ready}, 0);
        for (int i = 0; i < 5; i++) hwrite(8'h80 + 8'(i), 1);
        wait_busy_low();
        chk("R8 loaded block moves", n_bus, 5);

        // Count wrap: load 0 gives 256 blocks
        tgt_len = 16'd1; pulse_start(); load_cnt(8'd0);
        for (int b = 0; b < 256; b++) begin
            hwrite(8'(b), 1);
            wait_busy_low();
            if (b == 0) chk("R5 wrap to 255", {24'd0, blk_count}, 255);
        end
        chk("R5 wrap final", {29'd0, cnt_loaded, end_of_dma, last_byte_sent}, 3);

        // BSY monitoring
        scsi_req = 0; tgt_len = 16'd4; pulse_start();
        mon_bsy = 0; scsi_bsy = 0;
        load_cnt(8'd3);
        for (int i = 0; i < 4; i++) hwrite(8'h90 + 8'(i), 1);
        repeat (5) tick();
        chk("R9 bsy ignored unmonitored", {30'd0, dma_mode, cnt_loaded}, 3);
        mon_bsy = 1; tick();
        chk("R9 bsy drop aborts", {30'd0, dma_mode, cnt_loaded}, 0);
        n_bus = 0; scsi_req = 1;
        repeat (10) tick();
        chk("R9 bus stopped", n_bus, 0);
        exp_q.delete();
        scsi_bsy = 1; mon_bsy = 0;

        finish_run();
    end
endmodule